// File: doc/BRIEF.md
# I2C Message List Sequencer

This block sits above a batched I2C master core and turns a list of message descriptors into a series of core commands that form one bus transaction. Each descriptor gives a target address (7-bit or 10-bit), a read flag, a flag that continues the previous message without a new address phase, an ignore-NACK flag, a byte length, and a pointer into a local byte buffer. Software fills the descriptor array, sets the message count and a wait limit, and pulses `start`.

For each message the sequencer runs the address phase. A 7-bit address is a plain chip byte. A 10-bit address takes one or two immediate one-byte commands. The sequencer then cuts the payload into segments no larger than the core capacity, `CAP` = 8 × `REG_BYTES` bytes. Every command carries three condition flags: `restart` (repeated START), `nostart` (no START) and `nostop` (no STOP). These flags chain the whole list into one transaction that ends in a single STOP. Before each command the sequencer waits for the core's done flag to be clear. After each command it waits for the flag to rise, then clears the core. It finishes with a status code and the number of messages that completed.

States: `S_IDLE` → (`start`) `S_LOAD` (fetch descriptor, choose address form and message conditions) → `S_PLAN` (build the next command, or retire the message) → `S_WAIT_FREE` (core done flag must read low) → `S_ISSUE` (one-cycle `cmd_go`) → `S_WAIT_DONE` → `S_CLEAR` (one-cycle `core_clear`) → back to `S_PLAN`, or to `S_FINISH` on an abort. `S_PLAN` goes to `S_LOAD` for the next message, or to `S_FINISH` after the last one. `S_IDLE` goes straight to `S_FINISH` when the message count is zero. `S_FINISH` returns to `S_IDLE`.

Top module: `i2c_msg_seq`

## Requirements
- R1: For a 7-bit message, `cmd_chip` is {addr[6:0], rd}, and the first data segment carries this chip byte with `cmd_imm_en`=0.
- R2: For a 10-bit message, `cmd_chip` is {5'b11110, addr[9:8], 1'b0}. The first command is an immediate write (`cmd_imm_en`=1, `cmd_rd`=0, `cmd_len`=1, `cmd_ptr`=0, `cmd_ign_nack`=0) of addr[7:0], carrying the message conditions.
- R3: For a 10-bit read, a second immediate write of {`cmd_chip`[7:1], 1'b1} follows, with `restart`=1, `nostart`=0, `nostop`=1. Only then come the read segments, which keep the write-form chip byte.
- R4: The message conditions are all flags clear when the next message in the list has its no-start flag set; otherwise they are `restart`=1, `nostop`=1. A message with the no-start flag issues no address command and keeps the previous chip byte.
- R5: No segment is longer than `CAP` (32 bytes by default), and segments cover the payload in order, with `cmd_ptr` advancing by each segment length. A segment that is not the last of its message has `restart`=0 and `nostop`=1. Segments after the first take `nostart`=1.
- R6: The last segment of the last message has `restart`=0 and `nostop`=0, so it ends with STOP. The last segment of any other message carries the message conditions.
- R7: `cmd_go` is raised only in a cycle where `core_done` is low. If `core_done` stays high for `tmo_limit` cycles before a command, the list aborts with status 2.
- R8: If `core_done` does not rise within `tmo_limit` cycles after `cmd_go`, the list aborts with status 2.
- R9: A reported `core_nack` aborts the list with status 1, unless the command carries `cmd_ign_nack`=1 (data segments of a message flagged ignore-NACK). Immediate 10-bit address commands never ignore NACK.
- R10: Every command attempt is followed by exactly one single-cycle `core_clear` pulse. This holds whether the command was issued or abandoned waiting for the core.
- R11: On completion `done_o` pulses for one cycle, with `status_o` (0 ok, 1 NACK, 2 timeout) and `msg_count` equal to the number of messages fully finished. A list of zero messages finishes at once with status 0.
- R12: A 7-bit message of zero length issues no command and still counts as completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | IDX_W | Descriptor slot written |
| desc_addr | input | 10 | Target address (7-bit in bits 6:0) |
| desc_ten | input | 1 | 10-bit address form |
| desc_rd | input | 1 | Read message |
| desc_nostart | input | 1 | Continue previous message without address phase |
| desc_ign_nack | input | 1 | Ignore NACK on data segments |
| desc_len | input | LEN_W | Payload length in bytes |
| desc_ptr | input | PTR_W | Byte buffer start pointer |
| start | input | 1 | Begin processing the list |
| num_msgs | input | CNT_W | Number of messages in the list |
| tmo_limit | input | TMO_W | Wait limit in cycles |
| core_done | input | 1 | Core command-complete flag |
| core_nack | input | 1 | Core saw NACK (valid with core_done) |
| cmd_go | output | 1 | Command issue pulse |
| cmd_chip | output | 8 | Chip address byte |
| cmd_rd | output | 1 | Segment direction (1 read) |
| cmd_imm_en | output | 1 | Command sends the immediate byte |
| cmd_imm | output | 8 | Immediate byte |
| cmd_len | output | SEG_W | Segment byte count |
| cmd_ptr | output | PTR_W | Segment buffer pointer |
| cmd_restart | output | 1 | Repeated START condition |
| cmd_nostart | output | 1 | Suppress START |
| cmd_nostop | output | 1 | Suppress STOP |
| cmd_ign_nack | output | 1 | Core ignores NACK for this command |
| core_clear | output | 1 | Zero the core count and enable |
| done_o | output | 1 | List finished pulse |
| status_o | output | 2 | 0 ok, 1 NACK, 2 timeout |
| msg_count | output | CNT_W | Messages completed |

## Verification
The hardest case to reach is the wait before a command timing out. This needs a core whose done flag never drops, and the sequencer's own clear pulse always lowers a healthy core's flag. The bench's core model therefore has a stuck mode that holds the flag high and ignores clears. It also has a hang mode that never answers a command, which reaches the post-issue timeout. A NACK scripted on a chosen command index reaches aborts in the middle of a segment run and on the 10-bit address byte. A three-segment read and a no-start chain exercise every condition-flag combination.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef struct packed {
        logic restart;
        logic nostart;
        logic nostop;
    } cond_t;

    localparam cond_t COND_NONE  = '{restart: 1'b0, nostart: 1'b0, nostop: 1'b0};
    localparam cond_t COND_MSG   = '{restart: 1'b1, nostart: 1'b0, nostop: 1'b1};
    localparam cond_t COND_CHAIN = '{restart: 1'b0, nostart: 1'b1, nostop: 1'b1};

    typedef enum logic [1:0] {
        STAT_OK   = 2'd0,
        STAT_NACK = 2'd1,
        STAT_TMO  = 2'd2
    } stat_e;

    typedef enum logic [1:0] {
        PH_TEN_LO,
        PH_TEN_RD,
        PH_DATA
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_PLAN,
        S_WAIT_FREE,
        S_ISSUE,
        S_WAIT_DONE,
        S_CLEAR,
        S_FINISH
    } state_e;

endpackage

// File: rtl/seq_desc_mem.sv
module seq_desc_mem #(
    parameter int DEPTH    = 8,
    parameter int WIDTH    = 32,
    parameter int FLAG_BIT = 0,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic             flag_b
);
    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && waddr == IDX_W'(g))
                mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign flag_b  = mem[raddr_b][FLAG_BIT];
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = run && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_seg_plan.sv
module seq_seg_plan
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int SEG_W = 6,
    parameter int CAP   = 32
) (
    input  logic [LEN_W-1:0] remaining,
    input  cond_t            carry_cond,
    input  cond_t            msg_cond,
    input  logic             last_msg,
    output logic [SEG_W-1:0] seg_len,
    output cond_t            seg_cond,
    output logic [LEN_W-1:0] rem_after
);
    logic fits;

    always_comb begin
        fits = ({1'b0, remaining} <= (LEN_W + 1)'(CAP));
        seg_len = fits ? SEG_W'(remaining) : SEG_W'(CAP);
        if (!fits)
            seg_cond = '{restart: 1'b0, nostart: carry_cond.nostart, nostop: 1'b1};
        else if (last_msg)
            seg_cond = '{restart: 1'b0, nostart: carry_cond.nostart, nostop: 1'b0};
        else
            seg_cond = msg_cond;
        rem_after = remaining - LEN_W'(seg_len);
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int MAX_MSGS  = 8,
    parameter int LEN_W     = 8,
    parameter int PTR_W     = 8,
    parameter int REG_BYTES = 4,
    parameter int TMO_W     = 24,
    localparam int CAP      = 8 * REG_BYTES,
    localparam int SEG_W    = $clog2(CAP + 1),
    localparam int IDX_W    = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
    localparam int CNT_W    = $clog2(MAX_MSGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_we,
    input  logic [IDX_W-1:0] desc_idx,
    input  logic [9:0]       desc_addr,
    input  logic             desc_ten,
    input  logic             desc_rd,
    input  logic             desc_nostart,
    input  logic             desc_ign_nack,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [PTR_W-1:0] desc_ptr,
    input  logic             start,
    input  logic [CNT_W-1:0] num_msgs,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             core_done,
    input  logic             core_nack,
    output logic             cmd_go,
    output logic [7:0]       cmd_chip,
    output logic             cmd_rd,
    output logic             cmd_imm_en,
    output logic [7:0]       cmd_imm,
    output logic [SEG_W-1:0] cmd_len,
    output logic [PTR_W-1:0] cmd_ptr,
    output logic             cmd_restart,
    output logic             cmd_nostart,
    output logic             cmd_nostop,
    output logic             cmd_ign_nack,
    output logic             core_clear,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [CNT_W-1:0] msg_count
);
    typedef struct packed {
        logic [9:0]       addr;
        logic             ten;
        logic             rd;
        logic             ign;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
        logic             ns;
    } desc_t;

    state_e            state, nstate;
    phase_e            phase;
    desc_t             wr_desc, rd_desc;
    logic              nxt_ns_raw;
    logic [CNT_W-1:0]  msg_idx, nxt_idx, num_r, cnt_q;
    logic              last_msg, next_ns, abort_q, tmr_run, tmr_exp;
    stat_e             stat_q;
    cond_t             mcond, carry, cmd_cond, seg_cond;
    logic [LEN_W-1:0]  remaining, rem_after;
    logic [PTR_W-1:0]  ptr_r;
    logic [SEG_W-1:0]  seg_len;
    logic [7:0]        cur_lo8;
    logic              cur_rd, cur_ign;

    assign wr_desc = '{addr: desc_addr, ten: desc_ten, rd: desc_rd, ign: desc_ign_nack,
                       len: desc_len, ptr: desc_ptr, ns: desc_nostart};
    assign nxt_idx  = msg_idx + 1'b1;
    assign last_msg = (nxt_idx == num_r);
    assign next_ns  = (nxt_idx < num_r) && nxt_ns_raw;
    assign tmr_run  = (state == S_WAIT_FREE) || (state == S_WAIT_DONE);

    seq_desc_mem #(.DEPTH(MAX_MSGS), .WIDTH($bits(desc_t)), .FLAG_BIT(0)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(desc_we), .waddr(desc_idx), .wdata(wr_desc),
        .raddr_a(IDX_W'(msg_idx)), .raddr_b(IDX_W'(nxt_idx)),
        .rdata_a(rd_desc), .flag_b(nxt_ns_raw)
    );

    seq_wait_timer #(.W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmo_limit), .expired(tmr_exp)
    );

    seq_seg_plan #(.LEN_W(LEN_W), .SEG_W(SEG_W), .CAP(CAP)) u_plan (
        .remaining(remaining), .carry_cond(carry), .msg_cond(mcond), .last_msg(last_msg),
        .seg_len(seg_len), .seg_cond(seg_cond), .rem_after(rem_after)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:      if (start) nstate = (num_msgs == '0) ? S_FINISH : S_LOAD;
            S_LOAD:      nstate = S_PLAN;
            S_PLAN:      if (phase == PH_DATA && remaining == '0)
                             nstate = last_msg ? S_FINISH : S_LOAD;
                         else
                             nstate = S_WAIT_FREE;
            S_WAIT_FREE: if (!core_done)   nstate = S_ISSUE;
                         else if (tmr_exp) nstate = S_CLEAR;
            S_ISSUE:     nstate = S_WAIT_DONE;
            S_WAIT_DONE: if (core_done || tmr_exp) nstate = S_CLEAR;
            S_CLEAR:     nstate = abort_q ? S_FINISH : S_PLAN;
            S_FINISH:    nstate = S_IDLE;
            default:     nstate = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_go     = (state == S_ISSUE);
        core_clear = (state == S_CLEAR);
        done_o     = (state == S_FINISH);
    end

    assign cmd_restart = cmd_cond.restart;
    assign cmd_nostart = cmd_cond.nostart;
    assign cmd_nostop  = cmd_cond.nostop;
    assign status_o    = stat_q;
    assign msg_count   = cnt_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_DATA;   msg_idx <= '0;   num_r <= '0;    cnt_q <= '0;
            stat_q <= STAT_OK;  abort_q <= 1'b0; mcond <= COND_NONE; carry <= COND_NONE;
            remaining <= '0;    ptr_r <= '0;     cur_lo8 <= '0;  cur_rd <= 1'b0;
            cur_ign <= 1'b0;    cmd_chip <= '0;  cmd_rd <= 1'b0; cmd_imm_en <= 1'b0;
            cmd_imm <= '0;      cmd_len <= '0;   cmd_ptr <= '0;  cmd_cond <= COND_NONE;
            cmd_ign_nack <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    msg_idx <= '0; cnt_q <= '0; stat_q <= STAT_OK;
                    abort_q <= 1'b0; num_r <= num_msgs;
                end
                S_LOAD: begin
                    cur_lo8   <= rd_desc.addr[7:0];
                    cur_rd    <= rd_desc.rd;
                    cur_ign   <= rd_desc.ign;
                    mcond     <= next_ns ? COND_NONE : COND_MSG;
                    carry     <= next_ns ? COND_NONE : COND_MSG;
                    remaining <= rd_desc.len;
                    ptr_r     <= rd_desc.ptr;
                    if (!rd_desc.ns)
                        cmd_chip <= rd_desc.ten ? {5'b11110, rd_desc.addr[9:8], 1'b0}
                                                : {rd_desc.addr[6:0], rd_desc.rd};
                    phase <= (!rd_desc.ns && rd_desc.ten) ? PH_TEN_LO : PH_DATA;
                end
                S_PLAN: begin
                    unique case (phase)
                        PH_TEN_LO: begin
                            cmd_rd <= 1'b0; cmd_imm_en <= 1'b1; cmd_imm <= cur_lo8;
                            cmd_len <= SEG_W'(1); cmd_ptr <= '0; cmd_cond <= mcond;
                            cmd_ign_nack <= 1'b0;
                            phase <= cur_rd ? PH_TEN_RD : PH_DATA;
                        end
                        PH_TEN_RD: begin
                            cmd_rd <= 1'b0; cmd_imm_en <= 1'b1; cmd_imm <= {cmd_chip[7:1], 1'b1};
                            cmd_len <= SEG_W'(1); cmd_ptr <= '0; cmd_cond <= COND_MSG;
                            cmd_ign_nack <= 1'b0;
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            if (remaining == '0) begin
                                cnt_q   <= cnt_q + 1'b1;
                                msg_idx <= nxt_idx;
                            end else begin
                                cmd_rd <= cur_rd; cmd_imm_en <= 1'b0; cmd_imm <= '0;
                                cmd_len <= seg_len; cmd_ptr <= ptr_r; cmd_cond <= seg_cond;
                                cmd_ign_nack <= cur_ign;
                                remaining <= rem_after;
                                ptr_r <= ptr_r + PTR_W'(seg_len);
                                carry <= COND_CHAIN;
                            end
                        end
                        default: phase <= PH_DATA;
                    endcase
                end
                S_WAIT_FREE: if (core_done && tmr_exp) begin
                    abort_q <= 1'b1; stat_q <= STAT_TMO;
                end
                S_WAIT_DONE: begin
                    if (core_done) begin
                        if (core_nack && !cmd_ign_nack) begin
                            abort_q <= 1'b1; stat_q <= STAT_NACK;
                        end
                    end else if (tmr_exp) begin
                        abort_q <= 1'b1; stat_q <= STAT_TMO;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: issue only while the core's done flag reads clear
    a_r7_issue_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> !core_done);
    // R5: segment length stays within core capacity
    a_r5_seg_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> (cmd_len != '0 && int'(cmd_len) <= CAP));
    // R2: immediate address bytes are single-byte writes
    a_r2_imm_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_imm_en) |-> (cmd_len == SEG_W'(1) && !cmd_rd && !cmd_ign_nack));
    // R10: each issued command is followed by a clear before the next issue
    a_r10_clear_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (!cmd_go && !core_clear));
    a_r10_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_clear |=> !core_clear);
    // R11: done is a single pulse with a legal status
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r11_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o != 2'd3));
    // R8: waiting past the limit without a response ends in timeout status
    a_r8_done_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_DONE && tmr_exp && !core_done) |=> (status_o == 2'd2));
endmodule

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb;
    localparam int SEGMAX = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       desc_we = 1'b0;
    logic [2:0] desc_idx = '0;
    logic [9:0] desc_addr = '0;
    logic       desc_ten = 1'b0, desc_rd = 1'b0, desc_nostart = 1'b0, desc_ign_nack = 1'b0;
    logic [7:0] desc_len = '0, desc_ptr = '0;
    logic       start = 1'b0;
    logic [3:0] num_msgs = '0;
    logic [23:0] tmo_limit = 24'd200;
    logic       core_done = 1'b0, core_nack = 1'b0;
    logic       cmd_go, cmd_rd, cmd_imm_en, cmd_restart, cmd_nostart, cmd_nostop, cmd_ign_nack;
    logic [7:0] cmd_chip, cmd_imm, cmd_ptr;
    logic [5:0] cmd_len;
    logic       core_clear, done_o;
    logic [1:0] status_o;
    logic [3:0] msg_count;

    i2c_msg_seq u_dut (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx),
        .desc_addr(desc_addr), .desc_ten(desc_ten), .desc_rd(desc_rd),
        .desc_nostart(desc_nostart), .desc_ign_nack(desc_ign_nack), .desc_len(desc_len),
        .desc_ptr(desc_ptr), .start(start), .num_msgs(num_msgs), .tmo_limit(tmo_limit),
        .core_done(core_done), .core_nack(core_nack), .cmd_go(cmd_go), .cmd_chip(cmd_chip),
        .cmd_rd(cmd_rd), .cmd_imm_en(cmd_imm_en), .cmd_imm(cmd_imm), .cmd_len(cmd_len),
        .cmd_ptr(cmd_ptr), .cmd_restart(cmd_restart), .cmd_nostart(cmd_nostart),
        .cmd_nostop(cmd_nostop), .cmd_ign_nack(cmd_ign_nack), .core_clear(core_clear),
        .done_o(done_o), .status_o(status_o), .msg_count(msg_count)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // descriptor list held by the bench
    int d_addr[8], d_len[8], d_ptr[8];
    bit d_ten[8], d_rd[8], d_ns[8], d_ign[8];

    logic [37:0] exp_q[$];
    int n_issued = 0, n_clears = 0, nack_at = -1, pend = 0;
    bit hang_mode = 0, stuck_mode = 0, nack_now = 0;

    function automatic logic [37:0] pack_cmd(input logic [7:0] chip, input logic rd,
        input logic ie, input logic [7:0] imm, input logic [7:0] len, input logic [7:0] ptr,
        input logic rs, input logic ns, input logic np, input logic ign);
        return {chip, rd, ie, imm, len, ptr, rs, ns, np, ign};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // reference: expected command list derived from the requirements
    task automatic build_expected(input int n);
        logic [7:0] chip;
        chip = 8'h00;
        exp_q.delete();
        for (int m = 0; m < n; m++) begin
            bit nxt_ns;
            bit mrs, mnp, rs, ns, np;
            int rem, p;
            nxt_ns = (m + 1 < n) && d_ns[m + 1];
            mrs = !nxt_ns; mnp = !nxt_ns;
            if (!d_ns[m]) begin
                if (d_ten[m]) begin
                    chip = 8'hF0 | 8'((d_addr[m] >> 8) & 3) << 1;
                    exp_q.push_back(pack_cmd(chip, 0, 1, 8'(d_addr[m] & 255), 8'd1, 8'd0,
                                             mrs, 0, mnp, 0));
                    if (d_rd[m])
                        exp_q.push_back(pack_cmd(chip, 0, 1, chip | 8'h01, 8'd1, 8'd0,
                                                 1, 0, 1, 0));
                end else begin
                    chip = 8'(((d_addr[m] & 127) << 1) | int'(d_rd[m]));
                end
            end
            rem = d_len[m]; p = d_ptr[m];
            rs = mrs; ns = 0; np = mnp;
            while (rem > 0) begin
                int take;
                take = (rem > SEGMAX) ? SEGMAX : rem;
                if (rem <= SEGMAX) begin
                    if (m == n - 1) begin rs = 0; np = 0; end
                    else begin rs = mrs; ns = 0; np = mnp; end
                end else begin
                    rs = 0; np = 1;
                end
                exp_q.push_back(pack_cmd(chip, d_rd[m], 0, 8'd0, 8'(take), 8'(p),
                                         rs, ns, np, d_ign[m]));
                rem -= take; p = (p + take) & 255;
                rs = 0; ns = 1; np = 1;
            end
        end
    endtask

    // core model and per-command comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (core_clear) begin
                n_clears++;
                if (!stuck_mode) begin core_done = 1'b0; core_nack = 1'b0; end
            end
            if (cmd_go) begin
                logic [37:0] act;
                act = pack_cmd(cmd_chip, cmd_rd, cmd_imm_en, cmd_imm, 8'(cmd_len), cmd_ptr,
                               cmd_restart, cmd_nostart, cmd_nostop, cmd_ign_nack);
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL %s cmd%0d: got %h expected none", cur_tag, n_issued, act);
                end else begin
                    logic [37:0] e;
                    e = exp_q.pop_front();
                    if (act !== e) begin
                        bad++;
                        $display("FAIL %s cmd%0d: got %h expected %h", cur_tag, n_issued, act, e);
                    end
                end
                nack_now = (n_issued == nack_at);
                n_issued++;
                if (!hang_mode) pend = 3;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin core_done = 1'b1; core_nack = nack_now; end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_msg(input int i, input int addr, input bit ten, input bit rd,
                           input bit ns, input bit ign, input int len, input int ptr);
        d_addr[i] = addr; d_ten[i] = ten; d_rd[i] = rd; d_ns[i] = ns;
        d_ign[i] = ign; d_len[i] = len; d_ptr[i] = ptr;
    endtask

    task automatic run(input int n, input int nk, input int exp_stat, input int exp_cnt,
                       input int exp_issue, input int exp_clr, input string tag);
        int waited;
        cur_tag = tag;
        build_expected(n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            desc_we = 1'b1; desc_idx = 3'(i); desc_addr = 10'(d_addr[i]);
            desc_ten = d_ten[i]; desc_rd = d_rd[i]; desc_nostart = d_ns[i];
            desc_ign_nack = d_ign[i]; desc_len = 8'(d_len[i]); desc_ptr = 8'(d_ptr[i]);
        end
        @(negedge clk);
        desc_we = 1'b0;
        n_issued = 0; n_clears = 0; nack_at = nk; pend = 0;
        num_msgs = 4'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done_o && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, {tag, " done seen"}, int'(done_o), 1);
        check(int'(status_o) == exp_stat, {tag, " status"}, int'(status_o), exp_stat);
        check(int'(msg_count) == exp_cnt, {tag, " msg_count"}, int'(msg_count), exp_cnt);
        check(n_issued == exp_issue, {tag, " commands issued"}, n_issued, exp_issue);
        check(n_clears == exp_clr, {tag, " R10 clear pulses"}, n_clears, exp_clr);
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R11 done one cycle"}, int'(done_o), 0);
        stuck_mode = 0; hang_mode = 0; core_done = 1'b0; core_nack = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) set_msg(i, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(done_o == 1'b0 && cmd_go == 1'b0 && core_clear == 1'b0, "R11 reset outputs",
              int'({done_o, cmd_go, core_clear}), 0);
        check(status_o == 2'd0 && msg_count == 4'd0, "R11 reset status",
              int'({status_o, msg_count}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R6: single 7-bit write
        set_msg(0, 'h50, 0, 0, 0, 0, 5, 'h10);
        run(1, -1, 0, 1, 1, 1, "R1_R6 single write");

        // R5, R6: 70-byte read split into three segments
        set_msg(0, 'h1E, 0, 1, 0, 0, 70, 'h08);
        run(1, -1, 0, 1, 3, 3, "R5 segmented read");

        // R2, R3, R4: 7-bit write then 10-bit read
        set_msg(0, 'h33, 0, 0, 0, 0, 2, 'h00);
        set_msg(1, 'h2A5, 1, 1, 0, 0, 3, 'h20);
        run(2, -1, 0, 2, 4, 4, "R2_R3 ten-bit read");

        // R2: 10-bit write
        set_msg(0, 'h1C3, 1, 0, 0, 0, 40, 'hF0);
        run(1, -1, 0, 1, 3, 3, "R2 ten-bit write");

        // R4: no-start chain
        set_msg(0, 'h11, 0, 0, 0, 0, 4, 'h00);
        set_msg(1, 'h7F, 0, 0, 1, 0, 3, 'h40);
        run(2, -1, 0, 2, 2, 2, "R4 no-start chain");

        // R9: NACK on data aborts
        set_msg(0, 'h22, 0, 0, 0, 0, 4, 'h00);
        set_msg(1, 'h23, 0, 0, 0, 0, 4, 'h10);
        run(2, 0, 1, 0, 1, 1, "R9 nack abort");

        // R9: ignore-NACK message continues
        set_msg(0, 'h22, 0, 0, 0, 1, 4, 'h00);
        run(2, 0, 0, 2, 2, 2, "R9 nack ignored");

        // R9: 10-bit address byte NACK aborts despite ignore flag
        set_msg(0, 'h3FF, 1, 0, 0, 1, 2, 'h00);
        run(1, 0, 1, 0, 1, 1, "R9 ten-bit addr nack");

        // R9, R5: NACK in the middle segment of a long read
        set_msg(0, 'h1E, 0, 1, 0, 0, 70, 'h00);
        run(1, 1, 1, 0, 2, 2, "R9 mid-segment nack");

        // R8: core never answers
        tmo_limit = 24'd20;
        set_msg(0, 'h40, 0, 0, 0, 0, 3, 'h00);
        set_msg(1, 'h41, 0, 0, 0, 0, 3, 'h00);
        hang_mode = 1;
        run(2, -1, 2, 0, 1, 1, "R8 response timeout");

        // R7: core done flag stuck high before the first command
        stuck_mode = 1;
        @(negedge clk);
        core_done = 1'b1;
        run(1, -1, 2, 0, 0, 1, "R7 busy timeout");
        tmo_limit = 24'd200;

        // R12: zero-length 7-bit message
        set_msg(0, 'h05, 0, 0, 0, 0, 0, 'h00);
        set_msg(1, 'h06, 0, 1, 0, 0, 1, 'h03);
        run(2, -1, 0, 2, 1, 1, "R12 zero length");

        // R11: empty list
        run(0, -1, 0, 0, 0, 0, "R11 empty list");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule